// File: doc/BRIEF.md
# Sleep Clock-Stop Handshake Controller

This block sequences a chip into and out of its low-power state. An external run-enable input, held high in normal operation, is pulled low to ask for sleep. The controller first asks the internal logic to wind down through a stop request. It then waits until that logic reports that it is idle. Only then does it lower its oscillator-enable output, which tells the outside world that the clock may now be stopped, parked at logic low. Until the enable output falls, the clock must keep running. The lowered enable output is the chip's confirmation of that point.

When the run-enable input goes high again, the oscillator-enable output rises at once. The stop request is then held for a fixed stabilisation count, so the oscillator can settle before the internal logic resumes. If the run-enable input returns high while the controller is still waiting for the idle report, the sleep request is abandoned. In that case the oscillator-enable output never falls.

The controller also produces the reset seen by the internal logic. That reset is held low for a minimum number of clocks after the block's own reset is released. No sleep request is accepted until that reset has been released.

Top module: `sleep_handshake_ctrl`

## Requirements
- R1: While `rst_n` is sampled low, and in the cycle after, `osc_en_o` is 1, `quiesce_req_o` is 0 and `core_rst_n_o` is 0.
- R2: `core_rst_n_o` rises after exactly `RST_HOLD_CYCLES` rising clock edges with `rst_n` sampled high. It then stays high until the next reset.
- R3: `run_en_i` passes through a `SYNC_STAGES`-deep synchronizer that resets to 1 (run). With `core_rst_n_o` high, a low level on `run_en_i` raises `quiesce_req_o` on the (`SYNC_STAGES`+1)-th edge after it is applied, while `osc_en_o` stays 1.
- R4: A low `run_en_i` has no effect while `core_rst_n_o` is 0: `quiesce_req_o` stays 0.
- R5: While the stop request is pending, `osc_en_o` stays 1 until `idle_ack_i` is sampled high. It falls at that same edge.
- R6: If the synchronized enable is high while the stop request is pending, the controller returns to running: `quiesce_req_o` falls and `osc_en_o` never falls. This abort wins over an `idle_ack_i` that arrives at the same edge.
- R7: In sleep, `osc_en_o` stays 0 until the synchronized enable is high. It then rises at that edge, while `quiesce_req_o` stays 1.
- R8: After `osc_en_o` rises on wake, `quiesce_req_o` stays high for exactly `STAB_CYCLES` edges, then falls.
- R9: A low `run_en_i` during the stabilisation count does not shorten it. After the count ends, the controller runs for one cycle and then raises the stop request again.
- R10: `idle_ack_i` has no effect on the outputs while the controller is running.
- R11: `osc_en_o` is never 0 unless `quiesce_req_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; stopped low only while `osc_en_o` is 0 |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en_i | input | 1 | Asynchronous run enable; low asks for sleep |
| idle_ack_i | input | 1 | Internal logic reports it has gone quiet |
| quiesce_req_o | output | 1 | Stop request to internal logic |
| osc_en_o | output | 1 | Oscillator enable, active high; low means the clock may stop |
| core_rst_n_o | output | 1 | Stretched active-low reset for internal logic |

## Verification
The assertions assume that `rst_n` is synchronous to `clk`. They also assume that the clock keeps toggling whenever `osc_en_o` is high, so that every state change is seen on an edge. `idle_ack_i` is assumed to be a level that is only meaningful while the stop request is up. The bench drives every input on the falling clock edge, so the assumptions always hold. It keeps the clock running through sleep so that the wake path can be observed edge by edge. It also deliberately raises `idle_ack_i` while running, and in the same cycle as an abort, to exercise the cases where that signal must be ignored.

// File: rtl/slp_pkg.sv
// Shared types for the sleep clock-stop handshake controller.
// Assumes: nothing beyond IEEE 1800-2017 elaboration.
package slp_pkg;

    // Controller phases; encoding carries no external meaning.
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_QUIESCE = 2'd1,
        ST_READY   = 2'd2,
        ST_WAKE    = 2'd3
    } slp_state_t;

endpackage

// File: rtl/slp_sync.sv
// Multi-stage level synchronizer for one asynchronous input.
// Assumes: STAGES >= 1; the input is a slowly changing level, not a pulse.
module slp_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single flop capture of the asynchronous level.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= RESET_VAL;
                else        chain_q <= d_i;
            end
        end else begin : g_chain
            // Shift the level through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/slp_rst_hold.sv
// Stretches reset for internal logic to a minimum number of clocks.
// Assumes: HOLD_CYCLES >= 1; rst_n is synchronous to clk.
module slp_rst_hold #(
    parameter int HOLD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic core_rst_n_o
);

    localparam int                HW       = $clog2(HOLD_CYCLES + 1);
    localparam logic [HW-1:0]     HOLD_END = HW'(HOLD_CYCLES);

    logic [HW-1:0] cnt_q;

    // Count edges since reset release, saturating at the hold length.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (cnt_q != HOLD_END) cnt_q <= cnt_q + HW'(1);
    end

    assign core_rst_n_o = (cnt_q == HOLD_END);

endmodule

// File: rtl/slp_fsm.sv
// Sleep entry/exit sequencer: stop request, idle wait, clock release,
// wake with a stabilisation count.
// Assumes: run_en_s_i is already synchronous; STAB_CYCLES >= 1.
module slp_fsm
    import slp_pkg::*;
#(
    parameter int STAB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en_s_i,
    input  logic idle_ack_i,
    input  logic core_ready_i,
    output logic quiesce_req_o,
    output logic osc_en_o
);

    localparam int            CW        = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1;
    localparam logic [CW-1:0] STAB_LAST = CW'(STAB_CYCLES - 1);

    slp_state_t    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          osc_q, qreq_q;

    // Next-state and stabilisation-count decisions.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_RUN: begin
                if (!run_en_s_i && core_ready_i) st_d = ST_QUIESCE;
            end
            ST_QUIESCE: begin
                if (run_en_s_i)      st_d = ST_RUN;
                else if (idle_ack_i) st_d = ST_READY;
            end
            ST_READY: begin
                if (run_en_s_i) begin
                    st_d  = ST_WAKE;
                    cnt_d = STAB_LAST;
                end
            end
            ST_WAKE: begin
                if (cnt_q == '0) st_d  = ST_RUN;
                else             cnt_d = cnt_q - CW'(1);
            end
            default: st_d = ST_RUN;
        endcase
    end

    // State and count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_RUN;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Registered outputs so the pins never glitch on state decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osc_q  <= 1'b1;
            qreq_q <= 1'b0;
        end else begin
            osc_q  <= (st_d != ST_READY);
            qreq_q <= (st_d != ST_RUN);
        end
    end

    assign osc_en_o      = osc_q;
    assign quiesce_req_o = qreq_q;

endmodule

// File: rtl/sleep_handshake_ctrl.sv
// Top of the sleep clock-stop handshake controller.
// Assumes: rst_n synchronous to clk; run_en_i asynchronous; clk is only
// stopped (low) while osc_en_o is 0.
module sleep_handshake_ctrl #(
    parameter int SYNC_STAGES     = 2,
    parameter int STAB_CYCLES     = 16,
    parameter int RST_HOLD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en_i,
    input  logic idle_ack_i,
    output logic quiesce_req_o,
    output logic osc_en_o,
    output logic core_rst_n_o
);

    logic run_en_s;

    slp_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (run_en_i),
        .q_o   (run_en_s)
    );

    slp_rst_hold #(
        .HOLD_CYCLES (RST_HOLD_CYCLES)
    ) u_rst_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .core_rst_n_o (core_rst_n_o)
    );

    slp_fsm #(
        .STAB_CYCLES (STAB_CYCLES)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_en_s_i    (run_en_s),
        .idle_ack_i    (idle_ack_i),
        .core_ready_i  (core_rst_n_o),
        .quiesce_req_o (quiesce_req_o),
        .osc_en_o      (osc_en_o)
    );

endmodule

// File: rtl/slp_chk.sv
// Port-level property checker for sleep_handshake_ctrl, bound below.
// Assumes: rst_n synchronous to clk; clock running while osc_en_o is high.
module slp_chk #(
    parameter int STAB_CYCLES = 16
) (
    input logic clk,
    input logic rst_n,
    input logic idle_ack_i,
    input logic quiesce_req_o,
    input logic osc_en_o,
    input logic core_rst_n_o
);

    localparam int WW = $clog2(STAB_CYCLES + 2);

    logic          osc_d, wk_act;
    logic [WW-1:0] wk_cnt;

    // Measure how long the stop request stays up after a wake edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osc_d  <= 1'b1;
            wk_act <= 1'b0;
            wk_cnt <= '0;
        end else begin
            osc_d <= osc_en_o;
            if (osc_en_o && !osc_d) begin
                wk_act <= 1'b1;
                wk_cnt <= WW'(1);
            end else if (wk_act && quiesce_req_o) begin
                wk_cnt <= wk_cnt + WW'(1);
            end else if (!quiesce_req_o) begin
                wk_act <= 1'b0;
            end
        end
    end

    AST_CORE_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_n_o |=> core_rst_n_o); // R2

    AST_QUIESCE_RISE_KEEPS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(quiesce_req_o) |-> osc_en_o); // R3

    AST_NO_REQ_IN_CORE_RST: assert property (@(posedge clk) disable iff (!rst_n)
        !core_rst_n_o |-> !quiesce_req_o); // R4

    AST_OSC_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_en_o) |-> $past(idle_ack_i)); // R5

    AST_WAKE_HOLDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_en_o) |-> quiesce_req_o); // R7

    AST_STAB_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(quiesce_req_o) && wk_act) |-> (wk_cnt == WW'(STAB_CYCLES))); // R8

    AST_OSC_LOW_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en_o |-> quiesce_req_o); // R11

endmodule

bind sleep_handshake_ctrl slp_chk #(
    .STAB_CYCLES (STAB_CYCLES)
) u_slp_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .idle_ack_i    (idle_ack_i),
    .quiesce_req_o (quiesce_req_o),
    .osc_en_o      (osc_en_o),
    .core_rst_n_o  (core_rst_n_o)
);

// File: tb/sleep_handshake_ctrl_bench.sv
// Bench: behavioural reference model compared on every clock, plus
// directed checks at the handshake corners.
module sleep_handshake_ctrl_bench;

    localparam int SYNC = 2;
    localparam int STAB = 16;
    localparam int HOLD = 8;
    localparam int WD_CYCLES = 20000;

    logic clk = 1'b0;
    logic rst_n, run_en, idle_ack;
    logic quiesce_req, osc_en, core_rst_n;

    int    checks = 0;
    int    fails  = 0;
    string cur    = "R1";
    bit    osc_low_seen = 0;
    bit    done = 0;

    // Reference model state: 0 run, 1 stop pending, 2 asleep, 3 waking.
    int mst = 0;
    int rcnt = 0;
    int wcnt = 0;
    bit syncq[$];
    bit model_valid = 0;

    always #5 clk = ~clk;

    sleep_handshake_ctrl #(
        .SYNC_STAGES     (SYNC),
        .STAB_CYCLES     (STAB),
        .RST_HOLD_CYCLES (HOLD)
    ) u_sleep_handshake_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_en_i      (run_en),
        .idle_ack_i    (idle_ack),
        .quiesce_req_o (quiesce_req),
        .osc_en_o      (osc_en),
        .core_rst_n_o  (core_rst_n)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // Reference model advance at each rising edge.
    always @(posedge clk) begin
        bit en_s;
        en_s = (syncq.size() > 0) ? syncq[$] : 1'b1;
        if (!rst_n) begin
            syncq = {};
            for (int i = 0; i < SYNC; i++) syncq.push_back(1'b1);
            mst = 0; rcnt = 0; wcnt = 0;
        end else begin
            case (mst)
                0: if (!en_s && rcnt == HOLD) mst = 1;
                1: if (en_s) mst = 0; else if (idle_ack) mst = 2;
                2: if (en_s) begin mst = 3; wcnt = 0; end
                default: begin
                    wcnt++;
                    if (wcnt == STAB) mst = 0;
                end
            endcase
            syncq.push_front(run_en);
            void'(syncq.pop_back());
            if (rcnt < HOLD) rcnt++;
        end
        model_valid = 1;
    end

    // Compare against the model away from the active edge.
    always @(negedge clk) begin
        if (model_valid && !done) begin
            chk(cur, "osc_en_o vs model", osc_en, (mst != 2));
            chk(cur, "quiesce_req_o vs model", quiesce_req, (mst != 0));
            chk(cur, "core_rst_n_o vs model", core_rst_n, (rcnt == HOLD));
            if (!osc_en && !quiesce_req) chk("R11", "osc low without request", 1'b1, 1'b0);
            if (!osc_en) osc_low_seen = 1;
        end
    end

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; run_en = 1'b0; idle_ack = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1", "osc_en_o in reset", osc_en, 1'b1);
        chk("R1", "quiesce_req_o in reset", quiesce_req, 1'b0);
        chk("R1", "core_rst_n_o in reset", core_rst_n, 1'b0);

        // Sleep asked during the reset stretch: ignored (R4), then taken (R3).
        cur = "R4"; rst_n = 1'b1;
        repeat (HOLD - 1) @(negedge clk);
        chk("R2", "core_rst_n_o before hold end", core_rst_n, 1'b0);
        chk("R4", "no request while core in reset", quiesce_req, 1'b0);
        @(negedge clk);
        chk("R2", "core_rst_n_o at hold end", core_rst_n, 1'b1);
        chk("R4", "still no request at release edge", quiesce_req, 1'b0);
        cur = "R3";
        @(negedge clk);
        chk("R3", "request raised", quiesce_req, 1'b1);
        chk("R3", "osc kept during request", osc_en, 1'b1);

        // Waiting for idle.
        cur = "R5";
        repeat (5) @(negedge clk);
        chk("R5", "osc held until ack", osc_en, 1'b1);
        idle_ack = 1'b1;
        @(negedge clk);
        chk("R5", "osc dropped on ack", osc_en, 1'b0);
        idle_ack = 1'b0;

        // Wake.
        cur = "R7";
        repeat (3) @(negedge clk);
        chk("R7", "osc stays low asleep", osc_en, 1'b0);
        run_en = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7", "osc low during sync delay", osc_en, 1'b0);
        @(negedge clk);
        chk("R7", "osc raised on wake", osc_en, 1'b1);
        chk("R7", "request kept on wake", quiesce_req, 1'b1);
        cur = "R8";
        repeat (STAB - 1) @(negedge clk);
        chk("R8", "request held through count", quiesce_req, 1'b1);
        @(negedge clk);
        chk("R8", "request released after count", quiesce_req, 1'b0);

        // Ack while running has no effect.
        cur = "R10"; idle_ack = 1'b1;
        repeat (10) @(negedge clk);
        chk("R10", "no request from stray ack", quiesce_req, 1'b0);
        chk("R10", "osc high with stray ack", osc_en, 1'b1);
        idle_ack = 1'b0;

        // Abort before the ack.
        cur = "R6"; osc_low_seen = 0; run_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6", "request raised before abort", quiesce_req, 1'b1);
        run_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6", "request dropped on abort", quiesce_req, 1'b0);
        chk("R6", "osc never dropped on abort", osc_low_seen, 1'b0);

        // Abort and ack at the same edge: abort wins.
        run_en = 1'b0;
        repeat (3) @(negedge clk);
        run_en = 1'b1;
        repeat (2) @(negedge clk);
        idle_ack = 1'b1;
        @(negedge clk);
        chk("R6", "abort beats ack: request", quiesce_req, 1'b0);
        chk("R6", "abort beats ack: osc", osc_en, 1'b1);
        chk("R6", "abort beats ack: osc never low", osc_low_seen, 1'b0);
        idle_ack = 1'b0;

        // Sleep request during the stabilisation count.
        cur = "R9"; run_en = 1'b0;
        repeat (3) @(negedge clk);
        idle_ack = 1'b1;
        @(negedge clk);
        idle_ack = 1'b0; run_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9", "woke before new request", osc_en, 1'b1);
        run_en = 1'b0;
        repeat (STAB - 1) @(negedge clk);
        chk("R9", "count not shortened", quiesce_req, 1'b1);
        @(negedge clk);
        chk("R9", "one running cycle after count", quiesce_req, 1'b0);
        @(negedge clk);
        chk("R9", "request raised again", quiesce_req, 1'b1);

        // Reset mid-request.
        cur = "R1"; rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "osc_en_o after mid reset", osc_en, 1'b1);
        chk("R1", "quiesce_req_o after mid reset", quiesce_req, 1'b0);
        chk("R1", "core_rst_n_o after mid reset", core_rst_n, 1'b0);
        rst_n = 1'b1; run_en = 1'b1; cur = "R2";
        repeat (HOLD + 4) @(negedge clk);
        chk("R2", "core out of reset again", core_rst_n, 1'b1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule